// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. Each issued instruction claims the next slot of a circular buffer, and the slot number comes back as the instruction's tag. Execution units later broadcast results on a result bus, tagged with that number and in any order. The buffer retires instructions strictly from the oldest slot. A retiring register operation drives a register-file write port. A retiring store drives a memory write request.

While a result waits to retire, its slot number is the rename name for the value. Operand lookups by tag report whether the value has arrived and return it. A branch whose result bus write carries a misprediction flag discards every younger entry when it reaches the head. The next allocation then starts in the slot right after that branch.

The operation type field is encoded as 2'b00 for a register operation, 2'b01 for a store and 2'b10 for a branch. The destination field holds a register number (low `REG_W` bits) for register operations and a memory address for stores.

Top module: `rob_top`

## Requirements
- R1: After a synchronous reset the block reports empty=1 and full=0, alloc_tag=0, and reg_we, st_req and flush all 0.
- R2: Each accepted allocation takes the slot shown on alloc_tag, and successive allocations receive consecutive tags modulo DEPTH.
- R3: After DEPTH allocations with no retirement, full=1. A further allocation request is ignored: alloc_tag does not move, and a full drain retires exactly DEPTH entries before empty=1.
- R4: A result bus write (wb_valid) to an occupied slot stores wb_value and marks the slot ready. A lookup of that tag then shows lookup_ready=1 and the stored value.
- R5: Retirement is strictly in order: while the head slot has no result, nothing retires, even if younger slots are ready.
- R6: When the head is a ready register operation (kind 2'b00), reg_we=1 in that cycle, with reg_idx equal to the low REG_W bits of its destination and reg_data equal to its result. The head then advances by one at the next edge.
- R7: When the head is a ready store (kind 2'b01), st_req=1 with st_addr equal to its destination and st_data equal to its result, and reg_we=0.
- R8: A ready branch (kind 2'b10) without the misprediction flag retires with reg_we, st_req and flush all 0.
- R9: A ready branch whose result write carried wb_mispred=1 raises flush in the cycle it retires. After that edge the buffer is empty, younger slots report lookup_ready=0, and the next tag is the slot after the branch.
- R10: In a cycle where the buffer is full and the head retires, full reads 0, and an allocation in that cycle takes the freed slot.
- R11: A lookup of an unoccupied slot reports lookup_ready=0, and a result bus write to an unoccupied slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate a slot for a newly issued instruction |
| alloc_kind | input | 2 | Operation type: 00 register, 01 store, 10 branch |
| alloc_dest | input | 32 | Register number or store address |
| alloc_tag | output | TAG_W | Slot the next allocation takes |
| full | output | 1 | No slot free this cycle; issue must wait |
| empty | output | 1 | No occupied slot |
| wb_valid | input | 1 | Result bus write |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_value | input | 32 | Result value or store data |
| wb_mispred | input | 1 | Branch resolved against its prediction |
| lookup_tag | input | TAG_W | Operand lookup slot |
| lookup_ready | output | 1 | Looked-up slot holds a result |
| lookup_value | output | 32 | Looked-up result value |
| reg_we | output | 1 | Register file write enable |
| reg_idx | output | REG_W | Register file write index |
| reg_data | output | 32 | Register file write data |
| st_req | output | 1 | Store-to-memory request |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| flush | output | 1 | Misprediction discard, raised as the branch retires |

## Verification
The bench writes results back youngest first, so a buffer that retired whatever was ready would write registers out of order before the head was ready. It fills the buffer, then asks for one more slot. A design with a wrong wrap-bit comparison would overwrite the oldest entry and retire DEPTH+1 entries, or never drain. It retires and allocates in the same full cycle, where a full flag taken only from pointer state would drop a legal issue. It flushes on a mispredicted branch with ready younger results pending. A flush that missed any entry would show a stale ready lookup or extra register writes.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DATA_W = 32;
    localparam int ROB_DEST_W = 32;

    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10
    } op_kind_e;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic                  mispred;
        op_kind_e              kind;
        logic [ROB_DEST_W-1:0] dest;
        logic [ROB_DATA_W-1:0] value;
    } rob_entry_t;

    function automatic rob_entry_t fresh_entry(op_kind_e k, logic [ROB_DEST_W-1:0] d);
        rob_entry_t e;
        e.busy    = 1'b1;
        e.done    = 1'b0;
        e.mispred = 1'b0;
        e.kind    = k;
        e.dest    = d;
        e.value   = '0;
        return e;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int PTR_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic             full_q,
    output logic             empty_q
);

    logic [PTR_W-1:0] head_q, tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            head_q <= head_q + PTR_W'(1);
            tail_q <= head_q + PTR_W'(1);
        end else begin
            if (push) tail_q <= tail_q + PTR_W'(1);
            if (pop)  head_q <= head_q + PTR_W'(1);
        end
    end

    assign head_idx = head_q[TAG_W-1:0];
    assign tail_idx = tail_q[TAG_W-1:0];
    assign empty_q  = (head_q == tail_q);
    assign full_q   = (head_q[TAG_W] != tail_q[TAG_W]) &&
                      (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (PTR_W'(tail_q - head_q) <= PTR_W'(DEPTH)));

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (full_q && !pop) |-> !push);

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (head_q == tail_q));

    p_inorder_step_r5: assert property (@(posedge clk) disable iff (rst)
        pop |=> (head_q == $past(head_q) + PTR_W'(1)));

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  alloc_we,
    input  logic [TAG_W-1:0]      alloc_idx,
    input  op_kind_e              alloc_kind,
    input  logic [ROB_DEST_W-1:0] alloc_dest,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic [ROB_DATA_W-1:0] wb_value,
    input  logic                  wb_mispred,
    input  logic                  clear_we,
    input  logic [TAG_W-1:0]      clear_idx,
    input  logic [TAG_W-1:0]      head_idx,
    output rob_entry_t            head_entry,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic                  lk_ready,
    output logic [ROB_DATA_W-1:0] lk_value
);

    rob_entry_t ents [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rob_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (flush) begin
                slot_q.busy <= 1'b0;
                slot_q.done <= 1'b0;
            end else if (alloc_we && alloc_idx == TAG_W'(g)) begin
                slot_q <= fresh_entry(alloc_kind, alloc_dest);
            end else if (clear_we && clear_idx == TAG_W'(g)) begin
                slot_q.busy <= 1'b0;
                slot_q.done <= 1'b0;
            end else if (wb_valid && wb_tag == TAG_W'(g) && slot_q.busy) begin
                slot_q.done    <= 1'b1;
                slot_q.value   <= wb_value;
                slot_q.mispred <= wb_mispred;
            end
        end
        assign ents[g] = slot_q;
    end

    assign head_entry = ents[head_idx];
    assign lk_ready   = ents[lk_tag].busy && ents[lk_tag].done;
    assign lk_value   = ents[lk_tag].value;

    p_wb_marks_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && ents[wb_tag].busy && !flush &&
         !(alloc_we && alloc_idx == wb_tag) && !(clear_we && clear_idx == wb_tag))
        |=> (ents[$past(wb_tag)].done && ents[$past(wb_tag)].value == $past(wb_value)));

    p_idle_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !ents[wb_tag].busy && !(alloc_we && alloc_idx == wb_tag))
        |=> !ents[$past(wb_tag)].done);

endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  rob_entry_t            head_e,
    output logic                  commit,
    output logic                  reg_we,
    output logic [REG_W-1:0]      reg_idx,
    output logic [ROB_DATA_W-1:0] reg_data,
    output logic                  st_req,
    output logic [ROB_DEST_W-1:0] st_addr,
    output logic [ROB_DATA_W-1:0] st_data,
    output logic                  flush
);

    always_comb begin
        commit   = head_e.busy && head_e.done;
        reg_we   = 1'b0;
        st_req   = 1'b0;
        flush    = 1'b0;
        reg_idx  = head_e.dest[REG_W-1:0];
        reg_data = head_e.value;
        st_addr  = head_e.dest;
        st_data  = head_e.value;
        if (commit) begin
            unique case (head_e.kind)
                KIND_REG:    reg_we = 1'b1;
                KIND_STORE:  st_req = 1'b1;
                KIND_BRANCH: flush  = head_e.mispred;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int REG_W = 5,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_valid,
    input  logic [1:0]            alloc_kind,
    input  logic [ROB_DEST_W-1:0] alloc_dest,
    output logic [TAG_W-1:0]      alloc_tag,
    output logic                  full,
    output logic                  empty,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic [ROB_DATA_W-1:0] wb_value,
    input  logic                  wb_mispred,
    input  logic [TAG_W-1:0]      lookup_tag,
    output logic                  lookup_ready,
    output logic [ROB_DATA_W-1:0] lookup_value,
    output logic                  reg_we,
    output logic [REG_W-1:0]      reg_idx,
    output logic [ROB_DATA_W-1:0] reg_data,
    output logic                  st_req,
    output logic [ROB_DEST_W-1:0] st_addr,
    output logic [ROB_DATA_W-1:0] st_data,
    output logic                  flush
);

    logic [TAG_W-1:0] head_idx, tail_idx;
    logic             full_q, empty_q, commit, alloc_we;
    rob_entry_t       head_e;

    assign full      = full_q && !commit;
    assign empty     = empty_q;
    assign alloc_tag = tail_idx;
    assign alloc_we  = alloc_valid && !full && !flush;

    rob_ptrs #(.DEPTH(DEPTH)) ptrs_i (
        .clk(clk), .rst(rst), .push(alloc_we), .pop(commit), .flush(flush),
        .head_idx(head_idx), .tail_idx(tail_idx), .full_q(full_q), .empty_q(empty_q)
    );

    rob_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_we(alloc_we), .alloc_idx(tail_idx),
        .alloc_kind(op_kind_e'(alloc_kind)), .alloc_dest(alloc_dest),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispred(wb_mispred),
        .clear_we(commit), .clear_idx(head_idx),
        .head_idx(head_idx), .head_entry(head_e),
        .lk_tag(lookup_tag), .lk_ready(lookup_ready), .lk_value(lookup_value)
    );

    rob_retire #(.REG_W(REG_W)) retire_i (
        .head_e(head_e), .commit(commit),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .flush(flush)
    );

    p_one_action_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, st_req, flush}));

    p_commit_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        commit |-> !empty_q);

    p_slot_reuse_r10: assert property (@(posedge clk) disable iff (rst)
        (full_q && commit && !flush && alloc_valid) |=> full_q);

endmodule

// File: tb/rob_top_tb_top.sv
`timescale 1ns/1ps
module rob_top_tb_top;

    localparam int DEPTH = 8;
    localparam int TAG_W = 3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] dest;
        logic [31:0] value;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{kind: 2'b00, dest: 32'd5,     value: 32'hA5A5_0001},
        '{kind: 2'b01, dest: 32'h100,   value: 32'h0BAD_F00D},
        '{kind: 2'b10, dest: 32'd0,     value: 32'h0000_0000},
        '{kind: 2'b00, dest: 32'd31,    value: 32'h1234_5678}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic alloc_valid = 0, wb_valid = 0, wb_mispred = 0;
    logic [1:0] alloc_kind = 0;
    logic [31:0] alloc_dest = 0, wb_value = 0;
    logic [TAG_W-1:0] wb_tag = 0, lookup_tag = 0;
    logic [TAG_W-1:0] alloc_tag;
    logic full, empty, lookup_ready, reg_we, st_req, flush;
    logic [31:0] lookup_value, reg_data, st_addr, st_data;
    logic [4:0] reg_idx;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    rob_top #(.DEPTH(DEPTH), .REG_W(5)) dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_tag(alloc_tag), .full(full), .empty(empty),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispred(wb_mispred),
        .lookup_tag(lookup_tag), .lookup_ready(lookup_ready), .lookup_value(lookup_value),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .flush(flush)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic write_back(input logic [TAG_W-1:0] t, input logic [31:0] v, input logic m);
        wb_valid = 1; wb_tag = t; wb_value = v; wb_mispred = m;
        step();
        wb_valid = 0; wb_mispred = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int commits;
        repeat (3) step();
        rst = 0;
        // R1 reset state
        chk(empty == 1 && full == 0, "R1", "empty/full", {empty, full}, 2'b10);
        chk(alloc_tag == 0, "R1", "alloc_tag", alloc_tag, 0);
        chk({reg_we, st_req, flush} == 0, "R1", "actions", {reg_we, st_req, flush}, 0);
        lookup_tag = 3; #1;
        chk(lookup_ready == 0, "R11", "free slot lookup after reset", lookup_ready, 0);

        // table walk: allocate
        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1; alloc_kind = VECS[i].kind; alloc_dest = VECS[i].dest;
            #1;
            chk(alloc_tag == TAG_W'(i), "R2", "alloc tag", alloc_tag, i);
            step();
        end
        alloc_valid = 0;

        // write back youngest first: nothing may retire (R5)
        for (int i = 3; i >= 1; i--) begin
            write_back(TAG_W'(i), VECS[i].value, 1'b0);
            lookup_tag = TAG_W'(i); #1;
            chk(lookup_ready && lookup_value == VECS[i].value, "R4", "lookup after write",
                lookup_value, VECS[i].value);
            chk(!reg_we && !st_req && !flush, "R5", "no retire while head pending",
                {reg_we, st_req, flush}, 0);
        end
        write_back(0, VECS[0].value, 1'b0);

        // in-order retirement, one per cycle
        for (int k = 0; k < 4; k++) begin
            case (VECS[k].kind)
                2'b00: chk(reg_we && !st_req && reg_idx == VECS[k].dest[4:0] &&
                           reg_data == VECS[k].value, "R6", "register retire",
                           {reg_we, reg_idx, reg_data}, {1'b1, VECS[k].dest[4:0], VECS[k].value});
                2'b01: chk(st_req && !reg_we && st_addr == VECS[k].dest &&
                           st_data == VECS[k].value, "R7", "store retire",
                           {st_req, st_addr}, {1'b1, VECS[k].dest});
                default: chk(!reg_we && !st_req && !flush, "R8", "branch retire",
                             {reg_we, st_req, flush}, 0);
            endcase
            step();
        end
        chk(empty == 1, "R5", "empty after drain", empty, 1);

        // fill: tags 4..3
        for (int i = 0; i < DEPTH; i++) begin
            alloc_valid = 1; alloc_kind = 2'b00; alloc_dest = 32'(i);
            #1;
            chk(alloc_tag == TAG_W'(4 + i), "R2", "wrapping tag", alloc_tag, TAG_W'(4 + i));
            step();
        end
        chk(full == 1, "R3", "full after DEPTH allocs", full, 1);
        step();
        alloc_valid = 0;
        chk(full == 1 && alloc_tag == 4, "R3", "alloc while full ignored", {full, alloc_tag}, {1'b1, 3'd4});

        // retire head while full, allocate into freed slot (R10)
        write_back(4, 32'h4444, 1'b0);
        chk(full == 0 && reg_we == 1, "R10", "full drops on retire", {full, reg_we}, 2'b01);
        alloc_valid = 1; alloc_kind = 2'b00; alloc_dest = 32'd17;
        chk(alloc_tag == 4, "R10", "freed slot tag", alloc_tag, 4);
        step();
        alloc_valid = 0;
        chk(full == 1, "R10", "full again after reuse", full, 1);

        // drain all: exactly DEPTH retirements
        commits = 0;
        for (int k = 0; k < DEPTH; k++) begin
            write_back(TAG_W'(5 + k), 32'(100 + k), 1'b0);
            if (reg_we) commits++;
        end
        step();
        chk(commits == DEPTH, "R3", "retire count after full", commits, DEPTH);
        chk(empty == 1, "R3", "empty after drain", empty, 1);

        // misprediction flush (tags 5,6,7)
        alloc_valid = 1; alloc_kind = 2'b10; alloc_dest = 0; step();
        alloc_kind = 2'b00; alloc_dest = 7; step();
        alloc_dest = 9; step();
        alloc_valid = 0;
        write_back(6, 32'h66, 1'b0);
        write_back(7, 32'h77, 1'b0);
        chk(!reg_we, "R5", "younger ready, branch pending", reg_we, 0);
        write_back(5, 32'h0, 1'b1);
        chk(flush && !reg_we && !st_req, "R9", "flush on mispredicted branch",
            {flush, reg_we, st_req}, 3'b100);
        step();
        lookup_tag = 6; #1;
        chk(empty == 1 && !flush, "R9", "empty after flush", {empty, flush}, 2'b10);
        chk(lookup_ready == 0, "R9", "discarded slot lookup", lookup_ready, 0);
        chk(alloc_tag == 6, "R9", "next tag after branch", alloc_tag, 6);

        alloc_valid = 1; alloc_kind = 2'b00; alloc_dest = 3; step();
        alloc_valid = 0;
        write_back(6, 32'hCAFE, 1'b0);
        chk(reg_we && reg_idx == 3 && reg_data == 32'hCAFE, "R6", "retire after flush",
            {reg_idx, reg_data}, {5'd3, 32'hCAFE});
        step();

        // write to free slot ignored (R11)
        write_back(7, 32'hDEAD, 1'b0);
        lookup_tag = 7; #1;
        chk(lookup_ready == 0 && empty == 1 && !reg_we, "R11", "free-slot write ignored",
            {lookup_ready, empty, reg_we}, 3'b010);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule